// File: doc/BRIEF.md
# Timer Event Interrupt Router

This block sits between a bank of timer comparators and the interrupt fabric. Each timer hands it an expiry event together with its own configuration: whether it is enabled, whether it signals by level or by edge, which interrupt line it targets, and whether it should instead announce the event as a 32-bit message write. The router keeps a status bit per level-type timer, holds or pulses the chosen line, and ORs all contributions that land on the same line. Status-clear strobes, a disabled timer and a disabled global enable each drop a timer's status and held line.

A legacy-replacement mode takes over two fixed lines. Timer 0 is forced onto line 0 and timer 1 onto line 8, whatever their route fields hold. The same line 8 normally carries a pass-through real-time-clock interrupt level. That pass-through is muted while legacy mode is on and comes back at its live level when the mode is left. Message writes leave through a valid/ready port. Each timer may have at most one request waiting, and the lower timer index wins when several are waiting.

Top module: `tmr_irq_router`

## Requirements
- R1: Outside legacy mode, an event on a wired timer drives the line whose index equals that timer's route field.
- R2: In legacy mode, timer 0 drives line 0 and timer 1 drives line 8 regardless of route. Timers 2 and up keep using their route field.
- R3: A level-type event (type bit 1) sets the timer's status bit and holds its line high from the cycle after the event until it is cleared.
- R4: An edge-type event (type bit 0) gives exactly one cycle of high on the line and leaves the status bit at 0.
- R5: A status-clear strobe, a disabled timer or a disabled global enable clears the status bit and lowers the held line on the next cycle. A clear beats an event in the same cycle, and an event on an inactive timer has no effect.
- R6: With message routing on, an event raises no line and produces one request. Its address is bits 63:32 of that timer's 64-bit message route and its data is bits 31:0.
- R7: A request keeps valid, address and data stable until ready is seen. Repeated events on a timer that already has a request waiting are merged into one waiting request. Among waiting requests, the lowest timer index issues first.
- R8: Switching a timer's message routing from 0 to 1 lowers that timer's held wired line on the next cycle.
- R9: The RTC input level appears on line 8 only outside legacy mode. Entering legacy mode lowers it, and leaving legacy mode restores the current RTC level at once.
- R10: When several sources target one line, the line is the OR of all held levels, pulses and the pass-through.
- R11: The capability output has exactly one bit set, at line 2, marking that line as a routable target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy-replacement mode |
| tmr_en | input | NUM_TIMERS | Per-timer interrupt enable |
| tmr_level | input | NUM_TIMERS | Per-timer type: 1 level, 0 edge |
| msg_en | input | NUM_TIMERS | Per-timer message routing enable |
| route_sel | input | NUM_TIMERS*RW | Per-timer target line, RW bits each |
| msg_route | input | NUM_TIMERS*64 | Per-timer message route: address 63:32, data 31:0 |
| evt_set | input | NUM_TIMERS | Per-timer expiry event strobe |
| sts_clr | input | NUM_TIMERS | Per-timer status clear strobe |
| rtc_level | input | 1 | Pass-through RTC interrupt level |
| msg_ready | input | 1 | Message sink ready |
| irq_lines | output | NUM_LINES | Interrupt lines |
| irq_status | output | NUM_TIMERS | Per-timer status bits |
| msg_valid | output | 1 | Message request valid |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |
| cap_mask | output | NUM_LINES | Routable-line capability mask |

## Verification
The bench builds the router with four timers and sixteen lines. Four timers are enough to exercise both legacy-forced timers next to two ordinary ones, and two message requesters can compete for issue order. Sixteen lines put the route field's top value, line 15, within reach of a direct check. The same width still holds the fixed lines 0, 2 and 8, so legacy overrides, the shared line 8 and the capability bit are all checked at their real indices.

// File: rtl/tir_pkg.sv
package tir_pkg;

   localparam int MSG_ADDR_W = 32;
   localparam int MSG_DATA_W = 32;
   localparam int MSG_W      = MSG_ADDR_W + MSG_DATA_W;

   typedef struct packed {
      logic [MSG_ADDR_W-1:0] addr;
      logic [MSG_DATA_W-1:0] data;
   } msg_t;

endpackage

// File: rtl/tir_timer_slot.sv
module tir_timer_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic is_level,
   input  logic use_msg,
   input  logic evt,
   input  logic clr,
   output logic status,
   output logic wire_drv,
   output logic msg_req
);

   logic hold_q;
   logic pulse_q;
   logic status_q;
   logic use_msg_q;
   logic msg_rise;
   logic evt_ok;

   assign msg_rise = use_msg & ~use_msg_q;
   assign evt_ok   = evt & active & ~clr;
   assign msg_req  = evt_ok & use_msg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= 1'b0;
         pulse_q   <= 1'b0;
         status_q  <= 1'b0;
         use_msg_q <= 1'b0;
      end else begin
         use_msg_q <= use_msg;
         pulse_q   <= 1'b0;
         if (clr || !active) begin
            status_q <= 1'b0;
            hold_q   <= 1'b0;
         end else if (evt && !use_msg) begin
            if (is_level) begin
               status_q <= 1'b1;
               hold_q   <= 1'b1;
            end else begin
               pulse_q  <= 1'b1;
            end
         end
         if (msg_rise) begin
            hold_q <= 1'b0;
         end
      end
   end

   assign status   = status_q;
   assign wire_drv = hold_q | pulse_q;

   assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr || !active) |=> (!status_q && !hold_q));

   assert_msg_on_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msg_rise |=> !hold_q);

   assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> (!pulse_q || $past(evt)));

endmodule

// File: rtl/tir_line_merge.sv
module tir_line_merge #(
   parameter int NUM_TIMERS = 4,
   parameter int NUM_LINES  = 32,
   parameter int LEG_LINE_A = 0,
   parameter int LEG_LINE_B = 8,
   localparam int RW = $clog2(NUM_LINES)
) (
   input  logic [NUM_TIMERS-1:0]    drv,
   input  logic [NUM_TIMERS*RW-1:0] route_sel,
   input  logic                     legacy_en,
   input  logic                     rtc_level,
   output logic [NUM_LINES-1:0]     irq
);

   logic [RW-1:0] dest [NUM_TIMERS];

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_dest
      if (t == 0) begin : g_leg_a
         assign dest[t] = legacy_en ? RW'(LEG_LINE_A) : route_sel[t*RW +: RW];
      end else if (t == 1) begin : g_leg_b
         assign dest[t] = legacy_en ? RW'(LEG_LINE_B) : route_sel[t*RW +: RW];
      end else begin : g_plain
         assign dest[t] = route_sel[t*RW +: RW];
      end
   end

   always_comb begin
      irq = '0;
      for (int t = 0; t < NUM_TIMERS; t++) begin
         if (drv[t]) begin
            irq[dest[t]] = 1'b1;
         end
      end
      if (rtc_level && !legacy_en) begin
         irq[LEG_LINE_B] = 1'b1;
      end
   end

endmodule

// File: rtl/tir_msg_queue.sv
module tir_msg_queue
   import tir_pkg::*;
#(
   parameter int NUM_TIMERS = 4,
   localparam int IW = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_TIMERS-1:0]       req,
   input  logic [NUM_TIMERS*MSG_W-1:0] route,
   input  logic                        ready,
   output logic                        valid,
   output msg_t                        msg
);

   logic [NUM_TIMERS-1:0] pend_q;
   logic [NUM_TIMERS-1:0] pend_nxt;
   logic                  valid_q;
   msg_t                  msg_q;
   logic                  free;
   logic                  sel_ok;
   logic [IW-1:0]         sel;

   assign free = ~valid_q | ready;

   always_comb begin
      sel_ok = 1'b0;
      sel    = '0;
      for (int i = NUM_TIMERS - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            sel_ok = 1'b1;
            sel    = IW'(i);
         end
      end
   end

   always_comb begin
      pend_nxt = pend_q;
      if (free && sel_ok) begin
         pend_nxt[sel] = 1'b0;
      end
      pend_nxt = pend_nxt | req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         valid_q <= 1'b0;
         msg_q   <= '0;
      end else begin
         pend_q <= pend_nxt;
         if (free) begin
            valid_q <= sel_ok;
            if (sel_ok) begin
               msg_q <= msg_t'(route[sel*MSG_W +: MSG_W]);
            end
         end
      end
   end

   assign valid = valid_q;
   assign msg   = msg_q;

   assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready) |=> (valid_q && $stable(msg_q)));

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
   import tir_pkg::*;
#(
   parameter int NUM_TIMERS = 4,
   parameter int NUM_LINES  = 32,
   parameter int LEG_LINE_A = 0,
   parameter int LEG_LINE_B = 8,
   parameter int CAP_LINE   = 2,
   localparam int RW = $clog2(NUM_LINES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        glb_en,
   input  logic                        legacy_en,
   input  logic [NUM_TIMERS-1:0]       tmr_en,
   input  logic [NUM_TIMERS-1:0]       tmr_level,
   input  logic [NUM_TIMERS-1:0]       msg_en,
   input  logic [NUM_TIMERS*RW-1:0]    route_sel,
   input  logic [NUM_TIMERS*64-1:0]    msg_route,
   input  logic [NUM_TIMERS-1:0]       evt_set,
   input  logic [NUM_TIMERS-1:0]       sts_clr,
   input  logic                        rtc_level,
   input  logic                        msg_ready,
   output logic [NUM_LINES-1:0]        irq_lines,
   output logic [NUM_TIMERS-1:0]       irq_status,
   output logic                        msg_valid,
   output logic [31:0]                 msg_addr,
   output logic [31:0]                 msg_data,
   output logic [NUM_LINES-1:0]        cap_mask
);

   if (NUM_TIMERS < 2) begin : g_chk_timers
      $error("tmr_irq_router: NUM_TIMERS must be at least 2");
   end
   if ((1 << RW) != NUM_LINES) begin : g_chk_pow2
      $error("tmr_irq_router: NUM_LINES must be a power of two");
   end
   if (LEG_LINE_A >= NUM_LINES || LEG_LINE_B >= NUM_LINES || CAP_LINE >= NUM_LINES) begin : g_chk_lines
      $error("tmr_irq_router: fixed line index out of range");
   end
   if (MSG_W != 64) begin : g_chk_msg
      $error("tmr_irq_router: message route must be 64 bits");
   end

   logic [NUM_TIMERS-1:0] drv;
   logic [NUM_TIMERS-1:0] req;
   msg_t                  msg;

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_slot
      tir_timer_slot i_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (tmr_en[t] & glb_en),
         .is_level (tmr_level[t]),
         .use_msg  (msg_en[t]),
         .evt      (evt_set[t]),
         .clr      (sts_clr[t]),
         .status   (irq_status[t]),
         .wire_drv (drv[t]),
         .msg_req  (req[t])
      );
   end

   tir_line_merge #(
      .NUM_TIMERS (NUM_TIMERS),
      .NUM_LINES  (NUM_LINES),
      .LEG_LINE_A (LEG_LINE_A),
      .LEG_LINE_B (LEG_LINE_B)
   ) i_merge (
      .drv       (drv),
      .route_sel (route_sel),
      .legacy_en (legacy_en),
      .rtc_level (rtc_level),
      .irq       (irq_lines)
   );

   tir_msg_queue #(
      .NUM_TIMERS (NUM_TIMERS)
   ) i_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .route (msg_route),
      .ready (msg_ready),
      .valid (msg_valid),
      .msg   (msg)
   );

   assign msg_addr = msg.addr;
   assign msg_data = msg.data;

   always_comb begin
      cap_mask           = '0;
      cap_mask[CAP_LINE] = 1'b1;
   end

   assert_rtc_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_en && rtc_level) |-> irq_lines[LEG_LINE_B]);

   assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && drv == '0) |-> (irq_lines == '0));

   assert_cap_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cap_mask) == 1);

endmodule

// File: tb/test_tmr_irq_router.sv
`timescale 1ns/1ps
module test_tmr_irq_router;

   localparam int NT = 4;
   localparam int NL = 16;
   localparam int RW = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             glb_en = 1'b1;
   logic             legacy_en = 1'b0;
   logic [NT-1:0]    tmr_en = '1;
   logic [NT-1:0]    tmr_level = '1;
   logic [NT-1:0]    msg_en = '0;
   logic [NT*RW-1:0] route_sel = '0;
   logic [NT*64-1:0] msg_route;
   logic [NT-1:0]    evt_set = '0;
   logic [NT-1:0]    sts_clr = '0;
   logic             rtc_level = 1'b0;
   logic             msg_ready = 1'b0;
   logic [NL-1:0]    irq_lines;
   logic [NT-1:0]    irq_status;
   logic             msg_valid;
   logic [31:0]      msg_addr;
   logic [31:0]      msg_data;
   logic [NL-1:0]    cap_mask;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   initial begin
      for (int i = 0; i < NT; i++) begin
         msg_route[i*64 +: 64] = {32'hA000_0000 + 32'(i), 32'hD000_0000 + 32'(i)};
      end
   end

   tmr_irq_router #(.NUM_TIMERS(NT), .NUM_LINES(NL)) i_tmr_irq_router (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_en(legacy_en),
      .tmr_en(tmr_en), .tmr_level(tmr_level), .msg_en(msg_en),
      .route_sel(route_sel), .msg_route(msg_route), .evt_set(evt_set),
      .sts_clr(sts_clr), .rtc_level(rtc_level), .msg_ready(msg_ready),
      .irq_lines(irq_lines), .irq_status(irq_status), .msg_valid(msg_valid),
      .msg_addr(msg_addr), .msg_data(msg_data), .cap_mask(cap_mask)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_route(input int t, input int line);
      route_sel[t*RW +: RW] = RW'(line);
   endtask

   // drive an event for one cycle; returns at the negedge after the capturing edge
   task automatic fire(input logic [NT-1:0] m);
      evt_set = m;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic clear(input logic [NT-1:0] m);
      sts_clr = m;
      @(negedge clk);
      sts_clr = '0;
   endtask

   task automatic t_reset;
      chk("R5 reset lines", 64'(irq_lines), 64'h0);
      chk("R5 reset status", 64'(irq_status), 64'h0);
      chk("R7 reset valid", 64'(msg_valid), 64'h0);
      chk("R11 cap mask", 64'(cap_mask), 64'h4);
   endtask

   task automatic t_level_route;
      set_route(2, 5);
      fire(4'b0100);
      chk("R1 route line 5", 64'(irq_lines), 64'h20);
      chk("R3 status set", 64'(irq_status), 64'h4);
      repeat (3) @(negedge clk);
      chk("R3 level held", 64'(irq_lines), 64'h20);
      clear(4'b0100);
      chk("R5 clear line", 64'(irq_lines), 64'h0);
      chk("R5 clear status", 64'(irq_status), 64'h0);
   endtask

   task automatic t_edge;
      tmr_level[3] = 1'b0;
      set_route(3, 15);
      fire(4'b1000);
      chk("R4 pulse high line 15", 64'(irq_lines), 64'h8000);
      chk("R4 edge no status", 64'(irq_status), 64'h0);
      @(negedge clk);
      chk("R4 pulse one cycle", 64'(irq_lines), 64'h0);
      tmr_level[3] = 1'b1;
   endtask

   task automatic t_legacy;
      set_route(0, 3); set_route(1, 4); set_route(2, 6);
      legacy_en = 1'b1;
      fire(4'b0111);
      chk("R2 legacy routes", 64'(irq_lines), 64'h141);
      clear(4'b0111);
      legacy_en = 1'b0;
      fire(4'b0011);
      chk("R1 normal routes t0 t1", 64'(irq_lines), 64'h18);
      clear(4'b0011);
      chk("R5 cleared after legacy test", 64'(irq_lines), 64'h0);
   endtask

   task automatic t_disable;
      set_route(2, 5);
      tmr_en[2] = 1'b0;
      fire(4'b0100);
      chk("R5 event on disabled timer ignored line", 64'(irq_lines), 64'h0);
      chk("R5 event on disabled timer ignored status", 64'(irq_status), 64'h0);
      tmr_en[2] = 1'b1;
      fire(4'b0100);
      glb_en = 1'b0;
      @(negedge clk);
      chk("R5 global disable drops line", 64'(irq_lines), 64'h0);
      chk("R5 global disable drops status", 64'(irq_status), 64'h0);
      glb_en = 1'b1;
      sts_clr = 4'b0100;
      fire(4'b0100);
      sts_clr = '0;
      chk("R5 clear beats event", 64'(irq_status), 64'h0);
   endtask

   task automatic t_share;
      set_route(0, 7); set_route(3, 7);
      tmr_level[3] = 1'b0;
      fire(4'b0001);
      chk("R10 held source", 64'(irq_lines), 64'h80);
      sts_clr = 4'b0001;
      fire(4'b1000);
      sts_clr = '0;
      chk("R10 pulse keeps shared line", 64'(irq_lines), 64'h80);
      @(negedge clk);
      chk("R10 shared line released", 64'(irq_lines), 64'h0);
      tmr_level[3] = 1'b1;
   endtask

   task automatic t_rtc;
      rtc_level = 1'b1;
      #1 chk("R9 rtc passes", 64'(irq_lines), 64'h100);
      @(negedge clk);
      legacy_en = 1'b1;
      #1 chk("R9 legacy mutes rtc", 64'(irq_lines), 64'h0);
      rtc_level = 1'b0;
      @(negedge clk);
      rtc_level = 1'b1;
      #1 chk("R9 rtc toggles hidden", 64'(irq_lines), 64'h0);
      @(negedge clk);
      legacy_en = 1'b0;
      #1 chk("R9 exit restores live rtc", 64'(irq_lines), 64'h100);
      rtc_level = 1'b0;
      #1 chk("R9 rtc low follows", 64'(irq_lines), 64'h0);
      @(negedge clk);
   endtask

   task automatic t_msg_rise;
      set_route(2, 5);
      fire(4'b0100);
      chk("R8 line held before switch", 64'(irq_lines), 64'h20);
      msg_en[2] = 1'b1;
      @(negedge clk);
      chk("R8 switch drops line", 64'(irq_lines), 64'h0);
      chk("R8 no request from switch", 64'(msg_valid), 64'h0);
      clear(4'b0100);
   endtask

   task automatic t_msg;
      logic [23:0] seq;
      int          n;
      msg_en = 4'b1100;
      msg_ready = 1'b0;
      fire(4'b1100);
      chk("R6 no line in message mode", 64'(irq_lines), 64'h0);
      @(negedge clk);
      chk("R6 request valid", 64'(msg_valid), 64'h1);
      chk("R6 address high word", 64'(msg_addr), 64'hA000_0002);
      chk("R6 data low word", 64'(msg_data), 64'hD000_0002);
      fire(4'b0100);
      fire(4'b0100);
      chk("R7 stable while not ready", 64'({msg_valid, msg_data}), 64'h1_D000_0002);
      msg_ready = 1'b1;
      seq = '0;
      n = 0;
      for (int k = 0; k < 6; k++) begin
         if (msg_valid) begin
            seq = {seq[15:0], msg_data[7:0]};
            n++;
         end
         @(negedge clk);
      end
      msg_ready = 1'b0;
      chk("R7 merged request count", 64'(n), 64'd3);
      chk("R7 issue order", 64'(seq), 64'h020203);
      msg_en = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level_route();
      t_edge();
      t_legacy();
      t_disable();
      t_share();
      t_rtc();
      t_msg_rise();
      t_msg();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule